// File: doc/BRIEF.md
# Word-Read Receive Frame FIFO

This block is a circular store for received frames of varying length, kept as 32-bit words. A frame arrives one word per cycle from the receive path. The first word is a format word whose low field gives the frame length. The block checks before writing that the whole frame fits. It then commits the frame or drops all of it, and in both cases it raises a one-cycle event. A frame is visible to the reader only after its last word has been written.

Software reads the frames back one word at a time through a data port. The block tracks where each frame ends from the length field of that frame's first word, so it knows how many whole frames remain. It also drives the status the register file needs:
- empty, not-empty and full flags;
- the stored-frame count;
- the free space in words;
- the read and write pointers;
- a running count of accepted frames.

Command inputs discard every stored frame and clear the accepted-frame count. Reset is asynchronous and active low, and its release is expected to be synchronous to `clk`.

Top module: `rxq_word_fifo`

## Requirements
- R1: After reset the block reports `empty`=1, `not_empty`=0, `full`=0, `frame_count`=0, `free_words`=DEPTH, `rd_ptr`=0, `wr_ptr`=0, `rx_frames`=0 and `rd_data`=0.
- R2: Bits [6:0] of a frame's first word (its format word) hold the frame length in words minus one. A frame with field value F therefore takes F+1 words, counting the format word. Words come back from `rd_data` in the order they were written, and the store wraps past its last address (DEPTH is a power of two).
- R3: A frame is accepted when stored words plus its length is at most DEPTH. Accepted words are written on the cycles `wr_valid` is high, and idle cycles may fall between them. The cycle after the last word, `frame_count` and `rx_frames` rise by one, `free_words` falls by the length, and `ev_rcv` is high for exactly one cycle. None of these outputs changes before that cycle.
- R4: A frame that does not fit is dropped whole. `ev_ovr` is high for one cycle, in the cycle after its format word. Its remaining words are consumed without being stored, and no count changes.
- R5: `rd_data` shows the word at `rd_ptr`. A cycle with `rd_en` high while a frame is stored consumes that word, advances `rd_ptr` by one modulo DEPTH and raises `free_words` by one.
- R6: `frame_count` falls by one in the cycle after the last word of a frame is read, and not before. `empty` is high exactly when `frame_count` is zero, and `not_empty` is its inverse.
- R7: While `empty` is high, `rd_data` reads zero, and `rd_en` changes no pointer or count.
- R8: `full` is high exactly when DEPTH words are stored. `free_words` equals DEPTH minus the stored words. `wr_ptr` equals (`rd_ptr` + stored words) modulo DEPTH.
- R9: A cycle with `flush` high discards every stored frame, including a frame whose writing is under way or starts in that cycle; the rest of that frame is consumed without being stored and raises no event. Afterwards both pointers are zero, `free_words` is DEPTH and `rx_frames` is unchanged.
- R10: `clr_rx_count` sets `rx_frames` to zero and takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Incoming frame word present |
| wr_data | input | 32 | Incoming frame word |
| rd_en | input | 1 | Read strobe of the data port |
| rd_data | output | 32 | Word at the read pointer, zero when empty |
| flush | input | 1 | Discard all stored frames |
| clr_rx_count | input | 1 | Clear the accepted-frame counter |
| empty | output | 1 | No whole frame stored |
| not_empty | output | 1 | At least one whole frame stored |
| full | output | 1 | All words occupied |
| frame_count | output | $clog2(DEPTH)+1 | Whole frames stored |
| rd_ptr | output | $clog2(DEPTH) | Read word pointer |
| wr_ptr | output | $clog2(DEPTH) | Committed write word pointer |
| free_words | output | $clog2(DEPTH)+1 | Unoccupied words |
| rx_frames | output | RXCNT_W | Accepted-frame counter |
| ev_rcv | output | 1 | One-cycle pulse per accepted frame |
| ev_ovr | output | 1 | One-cycle pulse per rejected frame |

## Verification
The bench builds the block with DEPTH=16, so a few short frames fill it completely. This makes the exact-fit boundary reachable: the store is filled to the last word, the next frame is rejected by a single word, and a frame is written across the wrap of the address space. With that depth a field value larger than DEPTH also covers the case where one frame alone can never fit. It further exercises a flush arriving in the middle of a frame and a counter clear in the same cycle as an accepted frame.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int unsigned WORD_W      = 32;
  localparam int unsigned LEN_FIELD_W = 7;               // frame length field in the format word
  localparam int unsigned LEN_W       = LEN_FIELD_W + 1; // holds field + 1

  typedef enum logic [1:0] {
    WR_IDLE,
    WR_STORE,
    WR_DROP
  } wr_state_e;

  // Total words of a frame, format word included.
  function automatic logic [LEN_W-1:0] frame_len(input logic [LEN_FIELD_W-1:0] field);
    return {1'b0, field} + LEN_W'(1);
  endfunction

endpackage

// File: rtl/rxq_mem.sv
module rxq_mem #(
  parameter  int unsigned DEPTH = 256,
  parameter  int unsigned DW    = 32,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store_q[waddr] <= wdata;
    end
  end

  assign rdata = store_q[raddr];

endmodule

// File: rtl/rxq_writer.sv
module rxq_writer
  import rxq_pkg::*;
#(
  parameter  int unsigned DEPTH = 256,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned OW    = AW + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  input  logic [LEN_FIELD_W-1:0] fmt_field,
  input  logic                   flush,
  input  logic [OW-1:0]          occ,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_off,
  output logic                   commit,
  output logic [LEN_W-1:0]       commit_len,
  output logic                   reject
);

  wr_state_e        state_q, state_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [AW-1:0]    off_q, off_d;
  logic [LEN_W-1:0] len_in;
  logic             fits;

  always_comb begin
    len_in     = frame_len(fmt_field);
    fits       = (32'(occ) + 32'(len_in)) <= 32'(DEPTH);
    state_d    = state_q;
    left_d     = left_q;
    len_d      = len_q;
    off_d      = off_q;
    mem_we     = 1'b0;
    mem_off    = off_q;
    commit     = 1'b0;
    commit_len = len_q;
    reject     = 1'b0;
    unique case (state_q)
      WR_IDLE: begin
        if (wr_valid) begin
          left_d  = len_in - LEN_W'(1);
          len_d   = len_in;
          off_d   = AW'(1);
          mem_off = '0;
          if (flush) begin
            if (len_in != LEN_W'(1)) state_d = WR_DROP;
          end else if (!fits) begin
            reject = 1'b1;
            if (len_in != LEN_W'(1)) state_d = WR_DROP;
          end else begin
            mem_we = 1'b1;
            if (len_in == LEN_W'(1)) begin
              commit     = 1'b1;
              commit_len = len_in;
            end else begin
              state_d = WR_STORE;
            end
          end
        end
      end
      WR_STORE: begin
        if (wr_valid) begin
          mem_we = !flush;
          left_d = left_q - LEN_W'(1);
          off_d  = off_q + AW'(1);
          if (left_q == LEN_W'(1)) begin
            state_d = WR_IDLE;
            commit  = !flush;
          end else if (flush) begin
            state_d = WR_DROP;
          end
        end else if (flush) begin
          state_d = WR_DROP;
        end
      end
      WR_DROP: begin
        if (wr_valid) begin
          left_d = left_q - LEN_W'(1);
          if (left_q == LEN_W'(1)) state_d = WR_IDLE;
        end
      end
      default: state_d = WR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WR_IDLE;
      left_q  <= '0;
      len_q   <= '0;
      off_q   <= '0;
    end else if (wr_valid || flush) begin
      state_q <= state_d;
      left_q  <= left_d;
      len_q   <= len_d;
      off_q   <= off_d;
    end
  end

endmodule

// File: rtl/rxq_reader.sv
module rxq_reader
  import rxq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   adv,
  input  logic                   flush,
  input  logic [LEN_FIELD_W-1:0] head_field,
  output logic                   frame_end
);

  logic [LEN_W-1:0] rem_q, rem_d;

  // rem_q == 0 means the word at the read pointer opens a new frame.
  always_comb begin
    if (rem_q == '0) rem_d = frame_len(head_field) - LEN_W'(1);
    else             rem_d = rem_q - LEN_W'(1);
    frame_end = adv && (rem_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (flush) begin
      rem_q <= '0;
    end else if (adv) begin
      rem_q <= rem_d;
    end
  end

endmodule

// File: rtl/rxq_word_fifo.sv
module rxq_word_fifo
  import rxq_pkg::*;
#(
  parameter  int unsigned DEPTH   = 256,
  parameter  int unsigned RXCNT_W = 32,
  localparam int unsigned AW      = $clog2(DEPTH),
  localparam int unsigned OW      = AW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [31:0]        wr_data,
  input  logic               rd_en,
  output logic [31:0]        rd_data,
  input  logic               flush,
  input  logic               clr_rx_count,
  output logic               empty,
  output logic               not_empty,
  output logic               full,
  output logic [OW-1:0]      frame_count,
  output logic [AW-1:0]      rd_ptr,
  output logic [AW-1:0]      wr_ptr,
  output logic [OW-1:0]      free_words,
  output logic [RXCNT_W-1:0] rx_frames,
  output logic               ev_rcv,
  output logic               ev_ovr
);

  logic [AW-1:0]      tail_q, tail_d;
  logic [OW-1:0]      occ_q, occ_d;
  logic [OW-1:0]      fcnt_q, fcnt_d;
  logic [RXCNT_W-1:0] rxcnt_q, rxcnt_d;
  logic               ev_rcv_q, ev_ovr_q;
  logic [AW-1:0]      head;
  logic               mem_we, commit, reject, frame_end, adv, is_empty;
  logic [AW-1:0]      mem_off;
  logic [LEN_W-1:0]   commit_len;
  logic [WORD_W-1:0]  mem_rdata;

  assign head     = tail_q + occ_q[AW-1:0];
  assign is_empty = (fcnt_q == '0);
  assign adv      = rd_en && !is_empty && !flush;

  rxq_writer #(.DEPTH(DEPTH)) i_writer (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .fmt_field  (wr_data[LEN_FIELD_W-1:0]),
    .flush      (flush),
    .occ        (occ_q),
    .mem_we     (mem_we),
    .mem_off    (mem_off),
    .commit     (commit),
    .commit_len (commit_len),
    .reject     (reject)
  );

  rxq_mem #(.DEPTH(DEPTH), .DW(WORD_W)) i_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (head + mem_off),
    .wdata (wr_data),
    .raddr (tail_q),
    .rdata (mem_rdata)
  );

  rxq_reader i_reader (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (adv),
    .flush      (flush),
    .head_field (mem_rdata[LEN_FIELD_W-1:0]),
    .frame_end  (frame_end)
  );

  always_comb begin
    if (flush) begin
      tail_d = '0;
      occ_d  = '0;
      fcnt_d = '0;
    end else begin
      tail_d = adv ? tail_q + AW'(1) : tail_q;
      occ_d  = occ_q - OW'(adv) + (commit ? OW'(commit_len) : '0);
      fcnt_d = fcnt_q + OW'(commit) - OW'(frame_end);
    end
    if (clr_rx_count) rxcnt_d = '0;
    else if (commit)  rxcnt_d = rxcnt_q + RXCNT_W'(1);
    else              rxcnt_d = rxcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q   <= '0;
      occ_q    <= '0;
      fcnt_q   <= '0;
      rxcnt_q  <= '0;
      ev_rcv_q <= 1'b0;
      ev_ovr_q <= 1'b0;
    end else begin
      if (adv || commit || flush) begin
        tail_q <= tail_d;
        occ_q  <= occ_d;
        fcnt_q <= fcnt_d;
      end
      if (commit || clr_rx_count) begin
        rxcnt_q <= rxcnt_d;
      end
      ev_rcv_q <= commit;
      ev_ovr_q <= reject;
    end
  end

  assign rd_data     = is_empty ? '0 : mem_rdata;
  assign empty       = is_empty;
  assign not_empty   = !is_empty;
  assign full        = (occ_q == OW'(DEPTH));
  assign frame_count = fcnt_q;
  assign rd_ptr      = tail_q;
  assign wr_ptr      = head;
  assign free_words  = OW'(DEPTH) - occ_q;
  assign rx_frames   = rxcnt_q;
  assign ev_rcv      = ev_rcv_q;
  assign ev_ovr      = ev_ovr_q;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter  int unsigned DEPTH   = 256,
  parameter  int unsigned RXCNT_W = 32,
  localparam int unsigned AW      = $clog2(DEPTH),
  localparam int unsigned OW      = AW + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_en,
  input logic               flush,
  input logic               clr_rx_count,
  input logic               empty,
  input logic               full,
  input logic [OW-1:0]      frame_count,
  input logic [AW-1:0]      rd_ptr,
  input logic [OW-1:0]      free_words,
  input logic [RXCNT_W-1:0] rx_frames,
  input logic               ev_rcv,
  input logic               ev_ovr
);

  AST_RCV_HAS_FRAME: assert property (@(posedge clk) disable iff (!rst_n) ev_rcv |-> !empty); // R3
  AST_OVR_NO_GAIN: assert property (@(posedge clk) disable iff (!rst_n) ev_ovr |-> frame_count <= $past(frame_count)); // R4
  AST_EVENT_PAIR: assert property (@(posedge clk) disable iff (!rst_n) !(ev_rcv && ev_ovr)); // R4
  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n) rd_en && !empty && !flush |=> rd_ptr == $past(rd_ptr) + AW'(1)); // R5
  AST_EMPTY_READ_STILL: assert property (@(posedge clk) disable iff (!rst_n) rd_en && empty && !flush |=> $stable(rd_ptr)); // R7
  AST_FULL_HAS_FRAME: assert property (@(posedge clk) disable iff (!rst_n) full |-> !empty); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) flush |=> empty && free_words == OW'(DEPTH)); // R9
  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n) clr_rx_count |=> rx_frames == '0); // R10

endmodule

bind rxq_word_fifo rxq_chk #(.DEPTH(DEPTH), .RXCNT_W(RXCNT_W)) i_rxq_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_en        (rd_en),
  .flush        (flush),
  .clr_rx_count (clr_rx_count),
  .empty        (empty),
  .full         (full),
  .frame_count  (frame_count),
  .rd_ptr       (rd_ptr),
  .free_words   (free_words),
  .rx_frames    (rx_frames),
  .ev_rcv       (ev_rcv),
  .ev_ovr       (ev_ovr)
);

// File: tb/test_rxq_word_fifo.sv
module test_rxq_word_fifo;

  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int OW    = AW + 1;
  localparam int NVEC  = 6;
  // columns: length field, expected acceptance, word index preceded by an idle cycle (-1 none)
  localparam int VEC [NVEC][3] = '{
    '{3, 1, -1}, '{4, 1, 2}, '{5, 1, -1}, '{1, 0, -1}, '{0, 1, -1}, '{0, 0, -1}
  };

  logic          clk = 1'b0;
  logic          rst_n, wr_valid, rd_en, flush, clr_rx_count;
  logic [31:0]   wr_data, rd_data;
  logic          empty, not_empty, full, ev_rcv, ev_ovr;
  logic [OW-1:0] frame_count, free_words;
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [31:0]   rx_frames;

  rxq_word_fifo #(.DEPTH(DEPTH), .RXCNT_W(32)) i_rxq_word_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .flush(flush), .clr_rx_count(clr_rx_count),
    .empty(empty), .not_empty(not_empty), .full(full), .frame_count(frame_count),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .free_words(free_words), .rx_frames(rx_frames),
    .ev_rcv(ev_rcv), .ev_ovr(ev_ovr)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int rcv_seen, ovr_seen;
  logic [31:0] mq[$];
  int lq[$];
  int m_rdptr = 0, cur_left = 0, m_rx = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    rcv_seen += int'(ev_rcv);
    ovr_seen += int'(ev_ovr);
  endtask

  function automatic logic [31:0] word_of(input int f, input int k, input int field);
    if (k == 0) return 32'((f << 16) | (field & 32'h7f));
    return 32'h8000_0000 | 32'(f << 16) | 32'(k << 8);
  endfunction

  task automatic check_state(input string tag);
    chk({tag, " R6 frame_count"}, frame_count, lq.size());
    chk({tag, " R6 empty"}, empty, lq.size() == 0);
    chk({tag, " R6 not_empty"}, not_empty, lq.size() != 0);
    chk({tag, " R8 free_words"}, free_words, DEPTH - mq.size());
    chk({tag, " R8 full"}, full, mq.size() == DEPTH);
    chk({tag, " R5 rd_ptr"}, rd_ptr, m_rdptr);
    chk({tag, " R8 wr_ptr"}, wr_ptr, (m_rdptr + mq.size()) % DEPTH);
    chk({tag, " R3 rx_frames"}, rx_frames, m_rx);
  endtask

  task automatic send_frame(input string tag, input int f, input int field, input int exp_ok,
                            input int gap_at, input bit clr_last);
    int len = field + 1;
    rcv_seen = 0;
    ovr_seen = 0;
    for (int k = 0; k < len; k++) begin
      tick();
      if (k == gap_at) begin
        wr_valid = 1'b0;
        tick();
      end
      wr_valid     = 1'b1;
      wr_data      = word_of(f, k, field);
      clr_rx_count = clr_last && (k == len - 1);
    end
    tick();
    wr_valid     = 1'b0;
    clr_rx_count = 1'b0;
    tick();
    chk({tag, " R3 ev_rcv pulses"}, rcv_seen, exp_ok);
    chk({tag, " R4 ev_ovr pulses"}, ovr_seen, 1 - exp_ok);
    if (exp_ok != 0) begin
      for (int k = 0; k < len; k++) mq.push_back(word_of(f, k, field));
      lq.push_back(len);
      m_rx = clr_last ? 0 : m_rx + 1;
    end
  endtask

  task automatic read_words(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_en = 1'b1;
      #1;
      chk({tag, " R2 rd_data"}, rd_data, mq[0]);
      void'(mq.pop_front());
      m_rdptr = (m_rdptr + 1) % DEPTH;
      if (cur_left == 0) cur_left = lq[0];
      cur_left--;
      if (cur_left == 0) void'(lq.pop_front());
    end
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0; rd_en = 1'b0; flush = 1'b0; clr_rx_count = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty", empty, 1);
    chk("R1 not_empty", not_empty, 0);
    chk("R1 full", full, 0);
    chk("R1 frame_count", frame_count, 0);
    chk("R1 free_words", free_words, DEPTH);
    chk("R1 rd_ptr", rd_ptr, 0);
    chk("R1 wr_ptr", wr_ptr, 0);
    chk("R1 rx_frames", rx_frames, 0);
    chk("R1 rd_data", rd_data, 0);

    // R7 read of an empty store
    rd_en = 1'b1;
    #1 chk("R7 empty rd_data", rd_data, 0);
    @(negedge clk);
    rd_en = 1'b0;
    check_state("R7 after empty read");

    // Vector table: fill to exactly DEPTH, reject by one word, reject at full
    for (int v = 0; v < NVEC; v++) begin
      send_frame($sformatf("vec%0d", v), v, VEC[v][0], VEC[v][1], VEC[v][2], 1'b0);
      check_state($sformatf("vec%0d", v));
    end
    chk("R8 full after fill", full, 1);

    // R6 frame boundary: three words of a four-word frame keep the count
    read_words("R6 partial", 3);
    chk("R6 count held mid-frame", frame_count, 4);
    read_words("R6 last word", 1);
    chk("R6 count after frame end", frame_count, 3);
    check_state("R5 after first frame");

    // R2 wraparound write into the freed words
    send_frame("R2 wrap", 10, 3, 1, -1, 1'b0);
    check_state("R2 wrap");
    read_words("R2 drain", 16);
    check_state("R5 drained");

    // R7 empty read at a non-zero pointer
    @(negedge clk);
    rd_en = 1'b1;
    #1 chk("R7 empty rd_data again", rd_data, 0);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R7 rd_ptr unchanged", rd_ptr, m_rdptr);

    // R4 frame longer than the store, then a frame behind it stays aligned
    send_frame("R4 oversize", 11, 20, 0, -1, 1'b0);
    check_state("R4 oversize");
    send_frame("R4 follow-up", 12, 3, 1, -1, 1'b0);
    check_state("R4 follow-up");
    #1 chk("R4 follow-up head word", rd_data, mq[0]);

    // R9 flush while a frame is being written
    rcv_seen = 0; ovr_seen = 0;
    for (int k = 0; k < 2; k++) begin
      tick(); wr_valid = 1'b1; wr_data = word_of(13, k, 4);
    end
    tick(); wr_valid = 1'b0; flush = 1'b1;
    tick(); flush = 1'b0;
    mq.delete(); lq.delete(); m_rdptr = 0; cur_left = 0;
    for (int k = 2; k < 5; k++) begin
      tick(); wr_valid = 1'b1; wr_data = word_of(13, k, 4);
    end
    tick(); wr_valid = 1'b0;
    tick();
    chk("R9 no ev_rcv for flushed frame", rcv_seen, 0);
    chk("R9 no ev_ovr for flushed frame", ovr_seen, 0);
    check_state("R9 after flush");
    send_frame("R9 after flush", 14, 2, 1, -1, 1'b0);
    check_state("R9 frame after flush");
    read_words("R9 readback", 3);
    check_state("R9 readback");

    // R10 clear in the same cycle as an accepted frame, then a plain clear
    send_frame("R10 clr with commit", 15, 3, 1, -1, 1'b1);
    chk("R10 rx_frames cleared", rx_frames, 0);
    send_frame("R10 count again", 16, 1, 1, -1, 1'b0);
    chk("R10 rx_frames counts", rx_frames, 1);
    @(negedge clk); clr_rx_count = 1'b1;
    @(negedge clk); clr_rx_count = 1'b0;
    m_rx = 0;
    check_state("R10 plain clear");

    summary();
    $finish;
  end

endmodule